// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block decides which of three color channels (red, green, blue) an image front end samples next. A 9-bit configuration word holds a scan direction bit and three channel enable bits. From these the block runs in one of three modes. In three-channel mode it visits every channel. In two-channel mode it alternates between the two enabled channels. In one-channel mode it stays on the single enabled channel. A per-pixel restart pulse puts the selector on the first channel of the pixel group. A sample-advance strobe steps it to the next active channel in the chosen direction.

Configuration writes are staged. A written word sits in a pending register and moves to the active register only on the next restart pulse, so a pixel group is never split between two configurations. A write that sets any reserved bit is still staged, but it raises an error flag that stays up until a write with all reserved bits clear.

The selector is a state machine with three states, `CH_RED`, `CH_GRN` and `CH_BLU`. It has three transitions:
- **restart**: go to the first channel of the pending configuration.
- **advance**: go to the next enabled channel of the active configuration, wrapping at the end.
- **hold**: keep the current state.

Top module: `color_chan_seq`

## Requirements
- R1: After reset, the selector is on red (`ch_idx`=0, `ch_sel`=3'b001) and `cfg_err` is 0. The active and pending words both equal the default 9'h0C0: direction bit set, red only enabled. So an advance before any restart leaves the selector on red.
- R2: Bit 7 is the direction bit. Bits 6, 5 and 4 enable red, green and blue. When none or all three enable bits are set, the mode is three-channel. In that mode a restart puts the selector on red if bit 7 is 1, or on blue if bit 7 is 0.
- R3: In three-channel mode each advance steps red→green→blue→red when bit 7 is 1, and blue→green→red→blue when bit 7 is 0.
- R4: With exactly two enable bits set, a restart goes to the enabled channel that comes first in the direction's order. Each advance then alternates between the two enabled channels.
- R5: With exactly one enable bit set, a restart selects that channel and advances never move the selector.
- R6: A written word has no effect on the selector or the active mode until the next restart pulse. A write in the same cycle as a restart is not used by that restart.
- R7: When restart and advance arrive in the same cycle, the restart wins.
- R8: A write with any of bits 8, 3, 2, 1 or 0 set raises `cfg_err` from the next cycle. The flag clears on the next write with all of those bits clear. The word's direction and enable bits are still staged and applied at the next restart.
- R9: `ch_sel` is always one-hot, with bit 0 for red, bit 1 for green and bit 2 for blue. `ch_idx` is 0 for red, 1 for green and 2 for blue.
- R10: In a cycle with neither restart nor advance, the selector keeps its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 9 | Configuration word |
| pix_restart | input | 1 | Per-pixel restart pulse |
| smp_adv | input | 1 | Sample-advance strobe |
| ch_sel | output | 3 | One-hot channel select (bit 0 red) |
| ch_idx | output | 2 | Channel index (0 red, 1 green, 2 blue) |
| cfg_err | output | 1 | Reserved-bit write error flag |

## Verification
Two pairs of events can land in the same cycle. A restart can coincide with an advance, and a configuration write can coincide with a restart. Directed cases drive each pair together on purpose, and the random phase lets them collide freely. In each case the bench judges the result by checking that the restart's target comes from the word staged before that cycle, and that the advance is dropped.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int CFG_W    = 9;
    localparam int NCH      = 3;
    localparam int IDX_W    = $clog2(NCH);
    localparam int FLD_W    = 4;
    localparam int DIR_BIT  = 7;
    localparam int ENR_BIT  = 6;
    localparam int ENB_BIT  = 4;
    localparam logic [CFG_W-1:0] RSV_MASK  = 9'h10F;
    localparam logic [CFG_W-1:0] CFG_PWRON = 9'h0C0;

    typedef enum logic [IDX_W-1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    // stored functional field: direction and the three enables
    typedef struct packed {
        logic fwd;
        logic en_r;
        logic en_g;
        logic en_b;
    } field_t;

    // normalised mode: en[0] red, en[1] green, en[2] blue
    typedef struct packed {
        logic           fwd;
        logic [NCH-1:0] en;
    } mode_t;
endpackage

// File: rtl/ccs_cfg_store.sv
module ccs_cfg_store
    import ccs_pkg::*;
#(
    parameter int                 W       = CFG_W,
    parameter logic [CFG_W-1:0]   RST_VAL = CFG_PWRON,
    parameter logic [CFG_W-1:0]   RSV     = RSV_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         restart,
    output field_t       pend_o,
    output field_t       act_o,
    output logic         err_o
);
    localparam field_t FLD_RST = field_t'(RST_VAL[DIR_BIT:ENB_BIT]);

    field_t pend_q, act_q;
    logic   err_q;
    field_t wr_fld;
    logic   wr_bad;

    always_comb begin
        wr_fld = field_t'(wr_data[DIR_BIT:ENB_BIT]);
        wr_bad = |(wr_data & RSV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= FLD_RST;
            act_q  <= FLD_RST;
            err_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                pend_q <= wr_fld;
                err_q  <= wr_bad;
            end
            if (restart) begin
                act_q <= pend_q;
            end
        end
    end

    assign pend_o = pend_q;
    assign act_o  = act_q;
    assign err_o  = err_q;

    AST_ACT_ONLY_AT_RESTART: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(act_q)); // R6
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((wr_data & RSV) != '0)) |=> err_q); // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((wr_data & RSV) == '0)) |=> !err_q); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(err_q)); // R8
endmodule

// File: rtl/ccs_mode_decode.sv
module ccs_mode_decode
    import ccs_pkg::*;
#(
    parameter int N = NCH
) (
    input  field_t fld_i,
    output mode_t  mode_o
);
    logic [N-1:0] raw;

    always_comb begin
        raw = {fld_i.en_b, fld_i.en_g, fld_i.en_r};
        mode_o.fwd = fld_i.fwd;
        // none or all enabled selects the full three-channel walk
        if (raw == '0 || raw == '1) begin
            mode_o.en = '1;
        end else begin
            mode_o.en = raw;
        end
    end
endmodule

// File: rtl/ccs_chan_fsm.sv
module ccs_chan_fsm
    import ccs_pkg::*;
#(
    parameter int N = NCH,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    input  mode_t         act_mode_i,
    input  mode_t         nxt_mode_i,
    output logic [N-1:0]  sel_o,
    output logic [IW-1:0] idx_o
);
    chan_e state_q, state_d;

    function automatic chan_e first_of(input mode_t m);
        if (m.fwd) begin
            if (m.en[0])      return CH_RED;
            else if (m.en[1]) return CH_GRN;
            else              return CH_BLU;
        end else begin
            if (m.en[2])      return CH_BLU;
            else if (m.en[1]) return CH_GRN;
            else              return CH_RED;
        end
    endfunction

    function automatic chan_e step_of(input chan_e s, input mode_t m);
        chan_e r;
        r = s;
        unique case (s)
            CH_RED: begin
                if (m.fwd) r = m.en[1] ? CH_GRN : (m.en[2] ? CH_BLU : CH_RED);
                else       r = m.en[2] ? CH_BLU : (m.en[1] ? CH_GRN : CH_RED);
            end
            CH_GRN: begin
                if (m.fwd) r = m.en[2] ? CH_BLU : (m.en[0] ? CH_RED : CH_GRN);
                else       r = m.en[0] ? CH_RED : (m.en[2] ? CH_BLU : CH_GRN);
            end
            CH_BLU: begin
                if (m.fwd) r = m.en[0] ? CH_RED : (m.en[1] ? CH_GRN : CH_BLU);
                else       r = m.en[1] ? CH_GRN : (m.en[0] ? CH_RED : CH_BLU);
            end
            default: r = CH_RED;
        endcase
        return r;
    endfunction

    // transition selection: restart > advance > hold
    always_comb begin
        if (restart) begin
            state_d = first_of(nxt_mode_i);
        end else if (advance) begin
            state_d = step_of(state_q, act_mode_i);
        end else begin
            state_d = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_RED;
        else     state_q <= state_d;
    end

    always_comb begin
        sel_o = '0;
        idx_o = '0;
        unique case (state_q)
            CH_RED: begin sel_o = 3'b001; idx_o = 2'd0; end
            CH_GRN: begin sel_o = 3'b010; idx_o = 2'd1; end
            CH_BLU: begin sel_o = 3'b100; idx_o = 2'd2; end
            default: begin sel_o = 3'b001; idx_o = 2'd0; end
        endcase
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_o) == 1); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!restart && !advance) |=> $stable(state_q)); // R10
    AST_RESTART_ENABLED: assert property (@(posedge clk) disable iff (rst)
        restart |=> act_mode_i.en[state_q]); // R4
    AST_SINGLE_STILL: assert property (@(posedge clk) disable iff (rst)
        (!restart && advance && $countones(act_mode_i.en) == 1) |=> $stable(state_q)); // R5
    AST_ADV_MOVES_3CH: assert property (@(posedge clk) disable iff (rst)
        (!restart && advance && act_mode_i.en == 3'b111) |=> !$stable(state_q)); // R3
endmodule

// File: rtl/color_chan_seq.sv
module color_chan_seq
    import ccs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             pix_restart,
    input  logic             smp_adv,
    output logic [NCH-1:0]   ch_sel,
    output logic [IDX_W-1:0] ch_idx,
    output logic             cfg_err
);
    field_t pend_fld, act_fld;
    mode_t  pend_mode, act_mode;

    ccs_cfg_store #(.W(CFG_W), .RST_VAL(CFG_PWRON), .RSV(RSV_MASK)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_data),
        .restart (pix_restart),
        .pend_o  (pend_fld),
        .act_o   (act_fld),
        .err_o   (cfg_err)
    );

    ccs_mode_decode #(.N(NCH)) u_dec_pend (
        .fld_i  (pend_fld),
        .mode_o (pend_mode)
    );

    ccs_mode_decode #(.N(NCH)) u_dec_act (
        .fld_i  (act_fld),
        .mode_o (act_mode)
    );

    ccs_chan_fsm #(.N(NCH), .IW(IDX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .restart    (pix_restart),
        .advance    (smp_adv),
        .act_mode_i (act_mode),
        .nxt_mode_i (pend_mode),
        .sel_o      (ch_sel),
        .idx_o      (ch_idx)
    );
endmodule

// File: tb/sim_color_chan_seq.sv
`timescale 1ns/1ps
module sim_color_chan_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_data = '0;
    logic       pix_restart = 1'b0;
    logic       smp_adv = 1'b0;
    logic [2:0] ch_sel;
    logic [1:0] ch_idx;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    // reference state, field = {dir, en_r, en_g, en_b}
    logic [3:0] m_pend, m_act;
    int         m_ch;
    logic       m_err;

    always #2.5 clk = ~clk;

    color_chan_seq u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .pix_restart(pix_restart), .smp_adv(smp_adv),
        .ch_sel(ch_sel), .ch_idx(ch_idx), .cfg_err(cfg_err)
    );

    function automatic logic [2:0] b_mask(input logic [3:0] f);
        logic [2:0] m;
        m = {f[0], f[1], f[2]};
        if (m == 3'b000 || m == 3'b111) m = 3'b111;
        return m;
    endfunction

    function automatic int b_first(input logic [3:0] f);
        logic [2:0] m;
        m = b_mask(f);
        for (int k = 0; k < 3; k++) begin
            int c;
            c = f[3] ? k : 2 - k;
            if (m[c]) return c;
        end
        return 0;
    endfunction

    function automatic int b_next(input int cur, input logic [3:0] f);
        logic [2:0] m;
        m = b_mask(f);
        for (int k = 1; k < 3; k++) begin
            int c;
            c = f[3] ? (cur + k) % 3 : (cur + 3 - k) % 3;
            if (m[c]) return c;
        end
        return cur;
    endfunction

    task automatic chk(input string tag);
        logic [2:0] es;
        es = 3'b001 << m_ch;
        n_chk++;
        if (ch_idx !== 2'(m_ch) || ch_sel !== es || cfg_err !== m_err) begin
            n_bad++;
            $display("FAIL %s: idx=%0d sel=%b err=%b expected idx=%0d sel=%b err=%b",
                     tag, ch_idx, ch_sel, cfg_err, m_ch, es, m_err);
        end
    endtask

    // drive at negedge, model at posedge, compare at following negedge
    task automatic cyc(input logic w, input logic [8:0] d, input logic rs,
                       input logic ad, input string tag);
        cfg_wr = w; cfg_data = d; pix_restart = rs; smp_adv = ad;
        @(posedge clk);
        if (rs) begin
            m_ch  = b_first(m_pend);
            m_act = m_pend;
        end else if (ad) begin
            m_ch = b_next(m_ch, m_act);
        end
        if (w) begin
            m_pend = d[7:4];
            m_err  = |(d & 9'h10F);
        end
        @(negedge clk);
        cfg_wr = 1'b0; pix_restart = 1'b0; smp_adv = 1'b0;
        chk(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_pend = 4'b1100; m_act = 4'b1100; m_ch = 0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset");
        cyc(0, 0, 0, 1, "R1 adv after reset");
        cyc(0, 0, 0, 1, "R5 single red stays");
        // three-channel forward, staged write
        cyc(1, 9'h080, 0, 0, "R6 write staged");
        cyc(0, 0, 0, 1, "R6 old mode still in force");
        cyc(0, 0, 1, 0, "R2 restart fwd -> red");
        cyc(0, 0, 0, 1, "R3 fwd red->green");
        cyc(0, 0, 0, 1, "R3 fwd green->blue");
        cyc(0, 0, 0, 1, "R3 fwd blue->red");
        cyc(0, 0, 0, 0, "R10 idle hold");
        // three-channel reverse with none enabled
        cyc(1, 9'h000, 0, 0, "R6 write reverse");
        cyc(0, 0, 1, 0, "R2 restart rev -> blue");
        cyc(0, 0, 0, 1, "R3 rev blue->green");
        cyc(0, 0, 0, 1, "R3 rev green->red");
        cyc(0, 0, 0, 1, "R3 rev red->blue");
        // all enabled, reverse
        cyc(1, 9'h070, 0, 0, "R6 write all-en");
        cyc(0, 0, 1, 0, "R2 all enabled rev -> blue");
        // two-channel red+green forward and reverse
        cyc(1, 9'h0E0, 0, 0, "R4 write RG fwd");
        cyc(0, 0, 1, 0, "R4 restart -> red");
        cyc(0, 0, 0, 1, "R4 red->green");
        cyc(0, 0, 0, 1, "R4 green->red");
        cyc(1, 9'h060, 0, 0, "R4 write RG rev");
        cyc(0, 0, 1, 0, "R4 restart rev -> green");
        cyc(0, 0, 0, 1, "R4 rev green->red");
        cyc(1, 9'h050, 1, 0, "R6 write with restart");
        cyc(0, 0, 0, 1, "R4 RB rev not yet; uses RG");
        cyc(0, 0, 1, 1, "R7 restart beats advance");
        cyc(0, 0, 0, 1, "R4 RB rev blue->red");
        // single green
        cyc(1, 9'h020, 0, 0, "R5 write single green");
        cyc(0, 0, 1, 0, "R5 restart -> green");
        cyc(0, 0, 0, 1, "R5 adv ignored");
        cyc(0, 0, 0, 1, "R5 adv ignored again");
        // reserved bits
        cyc(1, 9'h1C0, 0, 0, "R8 err raised");
        cyc(0, 0, 0, 1, "R8 err held");
        cyc(1, 9'h0C0, 0, 0, "R8 err cleared");
        cyc(1, 9'h081, 0, 0, "R8 err raised bit0");
        cyc(0, 0, 1, 1, "R8 word applied + R7");
        cyc(0, 0, 0, 1, "R8 applied fwd red->green");
        cyc(1, 9'h090, 0, 0, "R8 valid write clears");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [8:0] d;
            logic w, rs, ad;
            d  = {1'b0, 4'($urandom), 4'b0};
            if (($urandom % 10) == 0) d = d | 9'($urandom) & 9'h10F;
            w  = ($urandom % 6) == 0;
            rs = ($urandom % 5) == 0;
            ad = ($urandom % 2) == 0;
            cyc(w, d, rs, ad, "R9 random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule